// File: doc/BRIEF.md
# Glitch-Free Master Clock Auto-Switch

This block picks the internal master clock from two sources: a free-running oscillator clock, which is always present, and the output clock of a PLL. A two-bit mode input pins the choice to either source or leaves it to automatic control. Under automatic control the block runs from the PLL while the PLL is locked. It moves to the oscillator as soon as lock is lost. It goes back to the PLL only after lock has been steady for a set number of oscillator cycles. A force-lock input makes the block treat the PLL as locked whatever the lock flag says, so automatic fallback never happens while it is set.

Every change of source is made by a cross-coupled enable handshake. The enable of the old source drops on that source's falling edge. The enable of the new source rises on its own falling edge, and only after the old source's enable has been seen low. Each high and low phase of the output is therefore at least as long as the shorter half period of the two sources. The lock flag is synchronized into the oscillator domain. A registered status bit in the oscillator domain reports which source is driving the output. Mode and force-lock are oscillator-domain inputs. The PLL clock must keep toggling while lock is lost, because its enable can only be released on one of its own edges.

Top module: `mclk_autoswitch`

## Requirements
- R1: While `rst` is high for at least 8 oscillator cycles, `clk_out` toggles at the oscillator rate and `src_pll` is 0.
- R2: With mode 2'b00 (forced oscillator), `clk_out` follows the oscillator clock and `src_pll` is 0, whatever the lock flag and force-lock say.
- R3: With mode 2'b01 (forced PLL), `clk_out` follows the PLL clock and `src_pll` is 1, even when the lock flag is low.
- R4: With mode 2'b10 or 2'b11 (automatic), `clk_out` follows the PLL clock while the qualified lock is true, and the oscillator clock otherwise.
- R5: In automatic mode, a low on the synchronized lock flag clears the qualified lock on the next oscillator cycle, and the output moves to the oscillator clock.
- R6: The qualified lock becomes true only after the synchronized lock flag has stayed high for HOLD_CYCLES consecutive oscillator cycles. A lock pulse shorter than that causes no switch to the PLL.
- R7: While `force_lock` is 1, the PLL counts as locked in automatic mode: the output moves to the PLL and stays there when the lock flag falls.
- R8: The two source enables are never both on at once, and no output phase is shorter than the shorter half period of the two source clocks.
- R9: `src_pll` is a registered oscillator-domain bit that is 1 exactly when the PLL source enable is on, delayed by the synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Free-running oscillator clock, also the control domain |
| clk_pll | input | 1 | PLL output clock |
| rst | input | 1 | Synchronous active-high reset |
| pll_locked | input | 1 | PLL lock flag, asynchronous |
| force_lock | input | 1 | Treat the PLL as locked regardless of the lock flag |
| mode | input | 2 | 00 forced oscillator, 01 forced PLL, 1x automatic |
| clk_out | output | 1 | Selected master clock |
| src_pll | output | 1 | 1 when the PLL drives the output, oscillator domain |

## Verification
The checker tests these properties on every oscillator cycle: the two source enables are never on together, each forced mode gives its fixed selection on the next cycle, a low synchronized lock drops the qualified lock at once, the qualified lock never rises without a high lock input, and the status bit never rises while the oscillator is still enabled. Other behaviours show only over a whole scenario, so the bench covers them. These are the output frequency after each switch, the absence of runt phases measured in time across switchovers between the two unrelated clocks, the full hold time before returning to the PLL, the rejection of short lock pulses, and the suppression of fallback by force-lock.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
  typedef enum logic [1:0] {
    MODE_OSC   = 2'b00,
    MODE_PLL   = 2'b01,
    MODE_AUTO  = 2'b10,
    MODE_AUTO2 = 2'b11
  } mclk_mode_e;
endpackage

// File: rtl/mclk_sync.sv
module mclk_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr <= RST_VAL;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= {STAGES{RST_VAL}};
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/mclk_lock_qual.sv
module mclk_lock_qual #(
  parameter int HOLD_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pll_locked,
  input  logic force_lock,
  output logic lock_eff,
  output logic lock_ok
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic          lock_s;
  logic          force_q;
  logic [CW-1:0] cnt;

  mclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_lock_sync (
    .clk(clk), .rst(rst), .d(pll_locked), .q(lock_s)
  );

  always_ff @(posedge clk) begin
    if (rst) force_q <= 1'b0;
    else     force_q <= force_lock;
  end

  assign lock_eff = lock_s | force_q;

  always_ff @(posedge clk) begin
    if (rst || !lock_eff) begin
      cnt     <= '0;
      lock_ok <= 1'b0;
    end else if (cnt == CW'(HOLD_CYCLES)) begin
      lock_ok <= 1'b1;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mclk_gf_mux.sv
module mclk_gf_mux #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_osc,
  input  logic clk_pll,
  input  logic rst,
  input  logic want_pll,
  output logic clk_out,
  output logic en_osc,
  output logic en_pll,
  output logic pll_active
);
  logic target;
  logic settled;
  logic pll_en_s;
  logic target_s;
  logic osc_en_s;

  // Oscillator side: the target only moves once the previous switch is complete
  assign settled = target ? (!en_osc && pll_en_s) : (en_osc && !pll_en_s);

  always_ff @(posedge clk_osc) begin
    if (rst)          target <= 1'b0;
    else if (settled) target <= want_pll;
  end

  mclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_pll_to_osc (
    .clk(clk_osc), .rst(rst), .d(en_pll), .q(pll_en_s)
  );

  always_ff @(negedge clk_osc) begin
    if (rst) en_osc <= 1'b1;
    else     en_osc <= !target && !pll_en_s;
  end

  // PLL side: enable only once the oscillator enable is seen low
  mclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_tgt_to_pll (
    .clk(clk_pll), .rst(rst), .d(target), .q(target_s)
  );

  mclk_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_osc_to_pll (
    .clk(clk_pll), .rst(rst), .d(en_osc), .q(osc_en_s)
  );

  always_ff @(negedge clk_pll) begin
    if (rst) en_pll <= 1'b0;
    else     en_pll <= target_s && !osc_en_s;
  end

  assign clk_out    = (clk_osc & en_osc) | (clk_pll & en_pll);
  assign pll_active = pll_en_s;
endmodule

// File: rtl/mclk_autoswitch.sv
module mclk_autoswitch
  import mclk_pkg::*;
#(
  parameter int HOLD_CYCLES = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_osc,
  input  logic       clk_pll,
  input  logic       rst,
  input  logic       pll_locked,
  input  logic       force_lock,
  input  logic [1:0] mode,
  output logic       clk_out,
  output logic       src_pll
);
  logic lock_eff;
  logic lock_ok;
  logic want_pll;
  logic en_osc;
  logic en_pll;

  mclk_lock_qual #(.HOLD_CYCLES(HOLD_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_qual (
    .clk(clk_osc), .rst(rst), .pll_locked(pll_locked), .force_lock(force_lock),
    .lock_eff(lock_eff), .lock_ok(lock_ok)
  );

  always_ff @(posedge clk_osc) begin
    if (rst) begin
      want_pll <= 1'b0;
    end else begin
      case (mclk_mode_e'(mode))
        MODE_OSC: want_pll <= 1'b0;
        MODE_PLL: want_pll <= 1'b1;
        default:  want_pll <= lock_ok;
      endcase
    end
  end

  mclk_gf_mux #(.SYNC_STAGES(SYNC_STAGES)) u_mux (
    .clk_osc(clk_osc), .clk_pll(clk_pll), .rst(rst), .want_pll(want_pll),
    .clk_out(clk_out), .en_osc(en_osc), .en_pll(en_pll), .pll_active(src_pll)
  );
endmodule

// File: rtl/mclk_autoswitch_chk.sv
module mclk_autoswitch_chk (
  input logic       clk_osc,
  input logic       rst,
  input logic [1:0] mode,
  input logic       want_pll,
  input logic       lock_eff,
  input logic       lock_ok,
  input logic       en_osc,
  input logic       en_pll,
  input logic       src_pll
);
  assert_no_overlap_R8: assert property (@(posedge clk_osc) disable iff (rst)
    !(en_osc && en_pll));

  assert_force_osc_R2: assert property (@(posedge clk_osc) disable iff (rst)
    (mode == 2'b00) |=> !want_pll);

  assert_force_pll_R3: assert property (@(posedge clk_osc) disable iff (rst)
    (mode == 2'b01) |=> want_pll);

  assert_auto_follow_R4: assert property (@(posedge clk_osc) disable iff (rst)
    (mode[1] && lock_ok) |=> want_pll);

  assert_fast_drop_R5: assert property (@(posedge clk_osc) disable iff (rst)
    !lock_eff |=> !lock_ok);

  assert_rise_needs_lock_R6: assert property (@(posedge clk_osc) disable iff (rst)
    $rose(lock_ok) |-> $past(lock_eff));

  assert_status_R9: assert property (@(posedge clk_osc) disable iff (rst)
    $rose(src_pll) |-> !en_osc);
endmodule

bind mclk_autoswitch mclk_autoswitch_chk u_chk (
  .clk_osc(clk_osc), .rst(rst), .mode(mode), .want_pll(want_pll),
  .lock_eff(lock_eff), .lock_ok(lock_ok), .en_osc(en_osc), .en_pll(en_pll),
  .src_pll(src_pll)
);

// File: tb/mclk_autoswitch_test.sv
`timescale 1ns/1ps
module mclk_autoswitch_test;
  localparam int HOLD = 16;
  localparam int WIN  = 60;   // oscillator cycles per frequency window

  logic       clk_osc = 1'b0;
  logic       clk_pll = 1'b0;
  logic       rst = 1'b1;
  logic       pll_locked = 1'b0;
  logic       force_lock = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       clk_out;
  logic       src_pll;

  int n_chk = 0;
  int n_bad = 0;
  int edge_cnt = 0;
  int runts = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;
  realtime last_edge = 0.0;

  mclk_autoswitch #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(2)) uut (
    .clk_osc(clk_osc), .clk_pll(clk_pll), .rst(rst), .pll_locked(pll_locked),
    .force_lock(force_lock), .mode(mode), .clk_out(clk_out), .src_pll(src_pll)
  );

  always #2.0 clk_osc = ~clk_osc;           // 250 MHz
  initial begin
    #0.7;
    forever #3.0 clk_pll = ~clk_pll;        // 6 ns period
  end

  always @(posedge clk_out) edge_cnt++;

  // shortest legal phase is the oscillator half period (2 ns)
  always @(clk_out) begin
    if (mon_on && ($realtime - last_edge) < 1.95) runts++;
    last_edge = $realtime;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk_osc);
    #1;
  endtask

  task automatic measure(output int n);
    int c0;
    c0 = edge_cnt;
    cyc(WIN);
    n = edge_cnt - c0;
  endtask

  task automatic wait_status(input logic v, input int limit, output int waited);
    waited = 0;
    while (src_pll !== v && waited < limit) begin
      cyc(1);
      waited++;
    end
  endtask

  task automatic check_freq(input string req, input bit pll);
    int n, e;
    measure(n);
    e = pll ? (WIN * 4) / 6 : WIN;
    chk(n >= e - 2 && n <= e + 2, req, n, e);
  endtask

  task automatic check_runts(input string req);
    chk(runts == 0, req, runts, 0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    cyc(10);
    chk(src_pll === 1'b0, "R1 status in reset", int'(src_pll), 0);
    mon_on = 1'b1;
    check_freq("R1 osc rate in reset", 1'b0);
    rst = 1'b0;
    cyc(5);
  endtask

  task automatic t_force_osc;
    mode = 2'b00; pll_locked = 1'b1; force_lock = 1'b1;
    cyc(HOLD + 60);
    chk(src_pll === 1'b0, "R2 status forced osc", int'(src_pll), 0);
    check_freq("R2 osc rate forced osc", 1'b0);
    force_lock = 1'b0;
    check_runts("R8 forced osc");
  endtask

  task automatic t_force_pll;
    int w;
    mode = 2'b01; pll_locked = 1'b0;
    wait_status(1'b1, 60, w);
    chk(src_pll === 1'b1, "R3 status forced pll", int'(src_pll), 1);
    cyc(5);
    check_freq("R3 pll rate forced pll", 1'b1);
    check_runts("R8 osc to pll");
  endtask

  task automatic t_auto_unlocked;
    int w;
    mode = 2'b10; pll_locked = 1'b0;
    wait_status(1'b0, 60, w);
    chk(src_pll === 1'b0, "R4 auto unlocked status", int'(src_pll), 0);
    cyc(5);
    check_freq("R4 auto unlocked osc rate", 1'b0);
    check_runts("R8 pll to osc");
  endtask

  task automatic t_lock_blip;
    int early;
    early = 0;
    pll_locked = 1'b1;
    cyc(5);
    pll_locked = 1'b0;
    repeat (60) begin
      cyc(1);
      if (src_pll !== 1'b0) early++;
    end
    chk(early == 0, "R6 short lock pulse ignored", early, 0);
  endtask

  task automatic t_auto_relock;
    int early, w;
    early = 0;
    pll_locked = 1'b1;
    repeat (HOLD) begin
      cyc(1);
      if (src_pll !== 1'b0) early++;
    end
    chk(early == 0, "R6 no switch before hold", early, 0);
    wait_status(1'b1, 60, w);
    chk(src_pll === 1'b1, "R4 auto locked status", int'(src_pll), 1);
    cyc(5);
    check_freq("R4 auto locked pll rate", 1'b1);
  endtask

  task automatic t_loss;
    int w;
    pll_locked = 1'b0;
    wait_status(1'b0, 40, w);
    chk(src_pll === 1'b0 && w < 40, "R5 fallback on loss", w, 40);
    cyc(5);
    check_freq("R5 osc rate after loss", 1'b0);
    check_runts("R8 loss of lock");
  endtask

  task automatic t_alt_auto;
    int w;
    mode = 2'b11; pll_locked = 1'b1;
    wait_status(1'b1, HOLD + 60, w);
    chk(src_pll === 1'b1, "R4 mode 11 auto locked", int'(src_pll), 1);
    pll_locked = 1'b0;
    wait_status(1'b0, 40, w);
    chk(src_pll === 1'b0, "R4 mode 11 auto loss", int'(src_pll), 0);
  endtask

  task automatic t_force_lock;
    int w, drop;
    drop = 0;
    mode = 2'b10; pll_locked = 1'b0; force_lock = 1'b1;
    wait_status(1'b1, HOLD + 60, w);
    chk(src_pll === 1'b1, "R7 force lock selects pll", int'(src_pll), 1);
    pll_locked = 1'b1;
    cyc(7);
    pll_locked = 1'b0;
    repeat (60) begin
      cyc(1);
      if (src_pll !== 1'b1) drop++;
    end
    chk(drop == 0, "R7 no fallback under force", drop, 0);
    check_freq("R7 pll rate under force", 1'b1);
    check_runts("R8 force lock");
    force_lock = 1'b0;
    wait_status(1'b0, HOLD + 60, w);
    chk(src_pll === 1'b0, "R9 status after force release", int'(src_pll), 0);
    cyc(5);
    check_freq("R9 osc rate matches status", 1'b0);
  endtask

  initial begin
    t_reset;
    t_force_osc;
    t_force_pll;
    t_auto_unlocked;
    t_lock_blip;
    t_auto_relock;
    t_loss;
    t_alt_auto;
    t_force_lock;
    check_runts("R8 whole run");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 4.0);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule